// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

The block raises a level interrupt request at a fixed, programmable interval. Time is measured in pulses of a reference clock enable rather than in system clock cycles. Each enable pulse passes through a fixed divide-by-4 stage. A select bit then chooses whether the result goes straight on or passes through a further divide-by-512 stage. The selected pulses count down an 8-bit modulus counter. When that counter reaches its terminal count, it reloads itself and the interrupt flag is set.

A configuration write loads a new modulus and a new prescaler selection together. The write restarts the whole chain from the new values. The interval is 4 × modulus × (1 or 512) reference enable pulses. A modulus of zero stops the timer. The interrupt request stays high until an acknowledge pulse clears it. System logic uses the block as a heartbeat or scheduler tick, and clears each tick with the acknowledge.

Top module: `tick_timer`

## Requirements
- R1: After reset, `irq` is low and the timer is idle: the modulus is zero and no interrupt occurs until a configuration write.
- R2: With `slow_sel` = 0 and modulus M (1..255), `irq` rises in the cycle after the 4·M-th `ref_tick` pulse that follows the configuration write. It is low after 4·M−1 pulses.
- R3: With `slow_sel` = 1 and modulus M, the interval is 4·512·M `ref_tick` pulses.
- R4: At terminal count the counter reloads the stored modulus, so each later interval has the same length without any new write.
- R5: A modulus of 0 disables the timer: no number of `ref_tick` pulses sets `irq`.
- R6: A pulse on `cfg_wr` stores `mod_in` and `slow_sel`, clears the divide stages and restarts the count from the new modulus. A `ref_tick` in the same cycle as `cfg_wr` is not counted.
- R7: `irq` is a level that stays high while `irq_ack` is low. It goes low in the cycle after an `irq_ack` pulse. `cfg_wr` does not change it.
- R8: When a terminal count and `irq_ack` fall in the same cycle, `irq` stays high.
- R9: Only cycles with `ref_tick` high advance the count. Any number of idle cycles between pulses changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference clock enable, one pulse per reference cycle |
| mod_in | input | MOD_W (8) | Modulus value loaded by a configuration write |
| slow_sel | input | 1 | Prescaler select loaded by a configuration write: 0 = ×1, 1 = ×512 |
| cfg_wr | input | 1 | Configuration write strobe |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can fall in the same cycle: the terminal count that sets the flag, and the acknowledge that clears it. The bench first leaves a pending request uncleared. It then drives `irq_ack` together with the reference pulse that completes the next interval, and requires `irq` to stay high after that edge. A separate acknowledge with no terminal count must then clear it. A second collision is a configuration write in the same cycle as a reference pulse. The bench judges it by checking that the following full interval is still exactly 4·M pulses long.

// File: rtl/tick_pkg.sv
package tick_pkg;
   // Default geometry of the tick chain
   localparam int unsigned DEF_MOD_W    = 8;
   localparam int unsigned DEF_FIX_DIV  = 4;
   localparam int unsigned DEF_SLOW_DIV = 512;

   // Counter width needed for a divide-by-n stage
   function automatic int unsigned stage_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tick_stage_div.sv
module tick_stage_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic carry
);
   localparam int unsigned CW = tick_pkg::stage_width(DIV);

   generate
      if (DIV < 1) begin : g_bad
         $error("tick_stage_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign carry = step;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          at_top;
         assign at_top = (cnt_q == CW'(DIV - 1));
         assign carry  = step & at_top;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (clr)
               cnt_q <= '0;
            else if (step)
               cnt_q <= at_top ? '0 : cnt_q + CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/tick_mod_counter.sv
module tick_mod_counter #(
   parameter int unsigned MOD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MOD_W-1:0] load_val,
   input  logic [MOD_W-1:0] reload_val,
   input  logic             step,
   output logic [MOD_W-1:0] cnt,
   output logic             term
);
   generate
      if (MOD_W < 1) begin : g_bad
         $error("tick_mod_counter: MOD_W must be at least 1");
      end
   endgenerate

   logic [MOD_W-1:0] cnt_q;
   logic             armed;

   assign armed = (reload_val != '0);
   assign term  = step & armed & (cnt_q == MOD_W'(1));
   assign cnt   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (step && armed)
         cnt_q <= term ? reload_val : cnt_q - MOD_W'(1);
   end
endmodule

// File: rtl/tick_irq_flag.sv
module tick_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic flag
);
   logic flag_q;
   assign flag = flag_q;

   // a set in the same cycle as an ack keeps the flag high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set)
         flag_q <= 1'b1;
      else if (ack)
         flag_q <= 1'b0;
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int unsigned MOD_W    = tick_pkg::DEF_MOD_W,
   parameter int unsigned FIX_DIV  = tick_pkg::DEF_FIX_DIV,
   parameter int unsigned SLOW_DIV = tick_pkg::DEF_SLOW_DIV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [MOD_W-1:0] mod_in,
   input  logic             slow_sel,
   input  logic             cfg_wr,
   input  logic             irq_ack,
   output logic             irq
);
   generate
      if (FIX_DIV < 1 || SLOW_DIV < 1) begin : g_bad
         $error("tick_timer: divide factors must be at least 1");
      end
   endgenerate

   logic [MOD_W-1:0] mod_q;
   logic             sel_q;
   logic             step_w, fix_c, slow_c, pre_c;
   logic [MOD_W-1:0] cnt_w;
   logic             term_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
         sel_q <= 1'b0;
      end else if (cfg_wr) begin
         mod_q <= mod_in;
         sel_q <= slow_sel;
      end
   end

   // a write takes priority over a reference pulse in the same cycle
   assign step_w = ref_tick & ~cfg_wr;

   tick_stage_div #(.DIV(FIX_DIV)) u_fix (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .step(step_w), .carry(fix_c)
   );

   tick_stage_div #(.DIV(SLOW_DIV)) u_slow (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .step(fix_c), .carry(slow_c)
   );

   assign pre_c = sel_q ? slow_c : fix_c;

   tick_mod_counter #(.MOD_W(MOD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_val(mod_in),
      .reload_val(mod_q), .step(pre_c), .cnt(cnt_w), .term(term_w)
   );

   tick_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(term_w), .ack(irq_ack), .flag(irq)
   );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int unsigned MOD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_tick,
   input logic             cfg_wr,
   input logic             irq_ack,
   input logic             irq,
   input logic [MOD_W-1:0] mod_in,
   input logic [MOD_W-1:0] mod_q,
   input logic [MOD_W-1:0] cnt,
   input logic             term
);
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);                                 // R7
   AST_TERM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> irq);                                              // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !term) |=> !irq);                               // R7
   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_q == '0) |-> !term);                                   // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_tick && !cfg_wr) |=> $stable(cnt));                   // R9
   AST_IDLE_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |-> !term);                                       // R9
   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cnt == $past(mod_in)));                         // R6
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr || (cnt <= mod_q));                                  // R4
endmodule

bind tick_timer tick_timer_chk #(.MOD_W(MOD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_wr(cfg_wr),
   .irq_ack(irq_ack), .irq(irq), .mod_in(mod_in), .mod_q(mod_q),
   .cnt(cnt_w), .term(term_w)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic [7:0] mod_in = '0;
   logic       slow_sel = 1'b0;
   logic       cfg_wr = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_timer i_tick_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mod_in(mod_in),
      .slow_sel(slow_sel), .cfg_wr(cfg_wr), .irq_ack(irq_ack), .irq(irq)
   );

   // {slow_sel, modulus}
   localparam int NV = 6;
   localparam logic [8:0] VEC [NV] = '{9'h001, 9'h003, 9'h0FF, 9'h080, 9'h101, 9'h102};

   function automatic int period(input logic sel, input logic [7:0] m);
      return 4 * int'(m) * (sel ? 512 : 1);
   endfunction

   task automatic check(input logic got, input logic exp, input string req);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: irq=%0b expected %0b", req, got, exp);
      end
   endtask

   // all tasks start and end at a negative clock edge
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         ref_tick = 1'b1;
         @(negedge clk);
      end
      ref_tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic config_wr(input logic sel, input logic [7:0] m);
      mod_in = m; slow_sel = sel; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check(irq, 1'b0, "R1 reset level");
      ticks(40);
      check(irq, 1'b0, "R1 idle after reset");

      // vector table: two intervals per entry
      for (int v = 0; v < NV; v++) begin
         int n;
         n = period(VEC[v][8], VEC[v][7:0]);
         config_wr(VEC[v][8], VEC[v][7:0]);
         ack();
         ticks(n - 1);
         check(irq, 1'b0, VEC[v][8] ? "R3 before interval" : "R2 before interval");
         ticks(1);
         check(irq, 1'b1, VEC[v][8] ? "R3 at interval" : "R2 at interval");
         ack();
         ticks(n - 1);
         check(irq, 1'b0, "R4 reload before second interval");
         ticks(1);
         check(irq, 1'b1, "R4 reload second interval");
         ack();
      end

      // R5: zero modulus stays silent
      config_wr(1'b0, 8'd0);
      ack();
      ticks(5000);
      check(irq, 1'b0, "R5 zero modulus");

      // R6: rewrite mid-count restarts from new modulus
      config_wr(1'b0, 8'd5);
      ticks(13);
      config_wr(1'b0, 8'd2);
      ticks(7);
      check(irq, 1'b0, "R6 restart before interval");
      ticks(1);
      check(irq, 1'b1, "R6 restart at interval");
      ack();

      // R6: prescaler stage cleared by a rewrite
      config_wr(1'b1, 8'd1);
      ticks(1500);
      config_wr(1'b1, 8'd1);
      ticks(2047);
      check(irq, 1'b0, "R6 prescaler cleared");
      ticks(1);
      check(irq, 1'b1, "R6 prescaler interval");
      // R7: write leaves a pending request alone
      config_wr(1'b0, 8'd3);
      check(irq, 1'b1, "R7 write keeps irq");
      ack();

      // R6: pulse during write is not counted
      mod_in = 8'd1; slow_sel = 1'b0; cfg_wr = 1'b1; ref_tick = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; ref_tick = 1'b0;
      ticks(3);
      check(irq, 1'b0, "R6 pulse with write ignored");
      ticks(1);
      check(irq, 1'b1, "R6 interval after write pulse");

      // R7: level held without acknowledge
      idle(30);
      check(irq, 1'b1, "R7 level held");
      ack();
      check(irq, 1'b0, "R7 ack clears");

      // R8: terminal count together with acknowledge
      ticks(4);
      check(irq, 1'b1, "R8 pending before collision");
      ticks(3);
      irq_ack = 1'b1; ref_tick = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0; ref_tick = 1'b0;
      check(irq, 1'b1, "R8 terminal wins over ack");
      ack();
      check(irq, 1'b0, "R8 later ack clears");

      // R9: idle cycles between pulses do not advance
      config_wr(1'b0, 8'd2);
      for (int i = 0; i < 7; i++) begin
         ticks(1);
         idle(20);
      end
      check(irq, 1'b0, "R9 gaps do not count");
      ticks(1);
      check(irq, 1'b1, "R9 interval with gaps");
      ack();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule